// File: doc/BRIEF.md
# DMA Descriptor Ring Walker

This block steps through a ring of four-word DMA descriptors that sit in system memory. Each descriptor is read one word at a time through a single-word memory port. If the host has handed the descriptor to the hardware, the walker gives the buffer address and byte count to an external data mover and waits for it to finish. It then writes word 0 back with the ownership bit cleared and moves on. The next descriptor comes either from the descriptor's own next pointer or, when its wrap flag is set, from the ring base. That base was captured on the last start strobe.

Descriptor layout:
- Word 0 holds the ownership bit at bit 31 (1 = hardware owns it) and 31 bits of host status that are kept as they are.
- Word 1 is the control word:
  - bit 31 asks for an interrupt on completion;
  - bit 29 marks the last segment of a frame;
  - bit 25 asks for a wrap to base;
  - bits 10..0 give the buffer size in bytes;
  - the other bits are ignored.
- Word 2 is the buffer address.
- Word 3 is the next-descriptor address.

The walker has ten states:
- IDLE: start goes to GET_OWN.
- GET_OWN: on the read acknowledge, an owned descriptor goes to GET_CTL and a host-owned one goes to PARK.
- GET_CTL goes to GET_BUF, GET_BUF to GET_NXT, and GET_NXT to CHECK, each on its read acknowledge.
- CHECK: a zero size goes to PUT_OWN, a malformed descriptor goes to FAULT, and anything else goes to MOVE.
- MOVE: the mover's done goes to PUT_OWN.
- PUT_OWN: the write acknowledge goes to GET_OWN at the next descriptor.
- PARK: start or poll goes to GET_OWN.
- FAULT has no exit except reset.

Top module: `dring_walker`

## Requirements
- R1: After reset the walker is in IDLE. `suspended`, `halted_err`, `irq`, `mem_req` and `mv_req` are all low, and no memory read is made until `start`. A `start` pulse in IDLE or PARK captures `base_addr` and begins fetching at that address.
- R2: Each descriptor at pointer P is read as words 0, 1, 2, 3 at byte addresses P, P+4, P+8, P+12, in that order. Each read holds `mem_req` and `mem_addr` steady until `mem_ack`, and `mem_rdata` is taken in the acknowledge cycle.
- R3: If word 0 bit 31 reads as 0, no further words are read and `suspended` goes high. No memory access is made until `poll` or `start` is pulsed. `poll` re-reads word 0 at the same pointer.
- R4: For an owned descriptor with a valid non-zero size, `mv_req` is raised with `mv_addr` = word 2 and `mv_len` = word 1 bits 10..0. It stays steady until `mv_done`.
- R5: A size of 0 raises no mover request. The descriptor is still written back, with no alignment check on its addresses.
- R6: After the mover's done (or straight after CHECK for size 0), word 0 is written at P with bit 31 cleared and bits 30..0 as read.
- R7: After the write-back, the next pointer is word 3, or the captured base when word 1 bit 25 is set.
- R8: A descriptor is malformed when its size is non-zero and any of these holds: the size is not a multiple of 4, the buffer address bits 1..0 are non-zero, or (wrap clear) the next pointer bits 1..0 are non-zero. A malformed descriptor sets `halted_err` with no mover request and no write-back. `halted_err` stays set, and start and poll are ignored, until reset.
- R9: `irq` is a one-cycle pulse in the cycle after the write-back acknowledge, raised only when word 1 bits 31 and 29 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures base_addr and starts fetching |
| base_addr | input | AW | Ring base byte address, word aligned |
| poll | input | 1 | Re-examine the parked descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| mv_req | output | 1 | Data mover request |
| mv_addr | output | AW | Buffer address for the mover |
| mv_len | output | LEN_W | Buffer size in bytes |
| mv_done | input | 1 | Mover finished the buffer |
| suspended | output | 1 | Parked on a host-owned descriptor |
| halted_err | output | 1 | Sticky malformed-descriptor flag |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A wrong latched field shows up within one descriptor. A bad buffer or length reaches the mover log, a wrong next pointer or missed wrap puts the wrong address in the read trace, and a corrupted status word shows as a wrong write-back in memory. A stuck or wrongly taken state shows as a missing park, a missing error or extra memory reads within a few cycles of the acknowledge that should have moved it. A sweep of every size residue against every buffer-address offset, with the wrap flag set, checks the skip, error and transfer decisions against arithmetic in the bench.

// File: rtl/dring_pkg.sv
package dring_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_GET_OWN, S_GET_CTL, S_GET_BUF, S_GET_NXT,
        S_CHECK, S_MOVE, S_PUT_OWN, S_PARK, S_FAULT
    } walk_state_t;

    localparam int OWN_BIT  = 31;
    localparam int IRQ_BIT  = 31;
    localparam int LAST_BIT = 29;
    localparam int WRAP_BIT = 25;
endpackage

// File: rtl/dring_desc_decode.sv
module dring_desc_decode #(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0] len,
    input  logic             wrap,
    input  logic [1:0]       buf_lo,
    input  logic [1:0]       nxt_lo,
    output logic             zero_len,
    output logic             bad_desc
);
    always_comb begin
        zero_len = (len == '0);
        bad_desc = !zero_len &&
                   ((len[1:0] != 2'b00) || (buf_lo != 2'b00) ||
                    (!wrap && (nxt_lo != 2'b00)));
    end
endmodule

// File: rtl/dring_addr_gen.sv
module dring_addr_gen #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] nxt,
    input  logic          wrap,
    input  logic [1:0]    word_idx,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] adv_addr
);
    localparam int OFS_W = 4;

    logic [OFS_W-1:0] ofs;

    always_comb begin
        ofs      = {word_idx, 2'b00};
        rd_addr  = ptr + AW'(ofs);
        adv_addr = wrap ? base : nxt;
    end
endmodule

// File: rtl/dring_walker.sv
module dring_walker
    import dring_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base_addr,
    input  logic             poll,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             mv_req,
    output logic [AW-1:0]    mv_addr,
    output logic [LEN_W-1:0] mv_len,
    input  logic             mv_done,
    output logic             suspended,
    output logic             halted_err,
    output logic             irq
);
    walk_state_t state_q, state_d;

    logic [AW-1:0]    ptr_q, base_q, buf_q, nxt_q;
    logic [30:0]      own_q;
    logic [LEN_W-1:0] len_q;
    logic             wrap_q, ic_q, ls_q, irq_q;
    logic [1:0]       word_idx;
    logic [AW-1:0]    rd_addr, adv_addr;
    logic             zero_len, bad_desc;
    logic             start_ok;

    assign start_ok = start && ((state_q == S_IDLE) || (state_q == S_PARK));

    dring_addr_gen #(.AW(AW)) addr_i (
        .ptr      (ptr_q),
        .base     (base_q),
        .nxt      (nxt_q),
        .wrap     (wrap_q),
        .word_idx (word_idx),
        .rd_addr  (rd_addr),
        .adv_addr (adv_addr)
    );

    dring_desc_decode #(.LEN_W(LEN_W)) dec_i (
        .len      (len_q),
        .wrap     (wrap_q),
        .buf_lo   (buf_q[1:0]),
        .nxt_lo   (nxt_q[1:0]),
        .zero_len (zero_len),
        .bad_desc (bad_desc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_GET_OWN;
            S_GET_OWN: if (mem_ack) state_d = mem_rdata[OWN_BIT] ? S_GET_CTL : S_PARK;
            S_GET_CTL: if (mem_ack) state_d = S_GET_BUF;
            S_GET_BUF: if (mem_ack) state_d = S_GET_NXT;
            S_GET_NXT: if (mem_ack) state_d = S_CHECK;
            S_CHECK: begin
                if (zero_len)      state_d = S_PUT_OWN;
                else if (bad_desc) state_d = S_FAULT;
                else               state_d = S_MOVE;
            end
            S_MOVE:    if (mv_done) state_d = S_PUT_OWN;
            S_PUT_OWN: if (mem_ack) state_d = S_GET_OWN;
            S_PARK:    if (start || poll) state_d = S_GET_OWN;
            S_FAULT:   state_d = S_FAULT;
            default:   state_d = S_IDLE;
        endcase
    end

    // descriptor fields, pointer and interrupt register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            base_q <= '0;
            buf_q  <= '0;
            nxt_q  <= '0;
            own_q  <= '0;
            len_q  <= '0;
            wrap_q <= 1'b0;
            ic_q   <= 1'b0;
            ls_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (start_ok) begin
                base_q <= base_addr;
                ptr_q  <= base_addr;
            end
            if (mem_ack) begin
                case (state_q)
                    S_GET_OWN: own_q <= mem_rdata[30:0];
                    S_GET_CTL: begin
                        len_q  <= mem_rdata[LEN_W-1:0];
                        wrap_q <= mem_rdata[WRAP_BIT];
                        ic_q   <= mem_rdata[IRQ_BIT];
                        ls_q   <= mem_rdata[LAST_BIT];
                    end
                    S_GET_BUF: buf_q <= mem_rdata[AW-1:0];
                    S_GET_NXT: nxt_q <= mem_rdata[AW-1:0];
                    S_PUT_OWN: begin
                        ptr_q <= adv_addr;
                        irq_q <= ic_q && ls_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        word_idx   = 2'd0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mv_req     = 1'b0;
        suspended  = 1'b0;
        halted_err = 1'b0;
        unique case (state_q)
            S_GET_OWN: mem_req = 1'b1;
            S_GET_CTL: begin mem_req = 1'b1; word_idx = 2'd1; end
            S_GET_BUF: begin mem_req = 1'b1; word_idx = 2'd2; end
            S_GET_NXT: begin mem_req = 1'b1; word_idx = 2'd3; end
            S_PUT_OWN: begin mem_req = 1'b1; mem_we = 1'b1; end
            S_MOVE:    mv_req = 1'b1;
            S_PARK:    suspended = 1'b1;
            S_FAULT:   halted_err = 1'b1;
            default: ;
        endcase
        mem_addr  = rd_addr;
        mem_wdata = {1'b0, own_q};
        mv_addr   = buf_q;
        mv_len    = len_q;
        irq       = irq_q;
    end
endmodule

// File: rtl/dring_walker_chk.sv
module dring_walker_chk #(
    parameter int AW    = 32,
    parameter int LEN_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             poll,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic             mv_req,
    input logic [AW-1:0]    mv_addr,
    input logic [LEN_W-1:0] mv_len,
    input logic             mv_done,
    input logic             suspended,
    input logic             halted_err,
    input logic             irq
);
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_park_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && !poll && !start |=> !mem_req);

    p_move_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req && !mv_done |=> mv_req && $stable(mv_addr) && $stable(mv_len));

    p_move_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> (mv_len != '0) && (mv_len[1:0] == 2'b00) && (mv_addr[1:0] == 2'b00));

    p_wb_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted_err |-> !mem_req && !mv_req);

    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted_err |=> halted_err);

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && mem_we && mem_ack));
endmodule

bind dring_walker dring_walker_chk #(.AW(AW), .LEN_W(LEN_W)) chk_i (.*);

// File: tb/dring_walker_tb_top.sv
module dring_walker_tb_top;
    localparam int AW    = 32;
    localparam int LEN_W = 11;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n, start, poll;
    logic [AW-1:0]    base_addr;
    logic             mem_req, mem_we, mem_ack;
    logic [AW-1:0]    mem_addr;
    logic [31:0]      mem_wdata, mem_rdata;
    logic             mv_req, mv_done;
    logic [AW-1:0]    mv_addr;
    logic [LEN_W-1:0] mv_len;
    logic             suspended, halted_err, irq;

    dring_walker #(.AW(AW), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .poll(poll),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mv_req(mv_req), .mv_addr(mv_addr), .mv_len(mv_len), .mv_done(mv_done),
        .suspended(suspended), .halted_err(halted_err), .irq(irq)
    );

    logic [31:0] mem [0:63];
    logic [31:0] rd_log [0:31];
    logic [31:0] mva_log [0:7];
    logic [31:0] mvl_log [0:7];
    int rd_cnt, mv_cnt, irq_cnt, irq_wide, lat;
    logic irq_d;
    int total = 0;
    int bad = 0;

    // memory responder: one access per two cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            rd_cnt    <= 0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            else begin
                mem_rdata <= mem[mem_addr[7:2]];
                if (rd_cnt < 32) rd_log[rd_cnt] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // data mover model: done three cycles into the request
    always @(posedge clk) begin
        if (!rst_n) begin
            mv_done <= 1'b0;
            lat     <= 0;
            mv_cnt  <= 0;
        end else if (mv_req && !mv_done) begin
            if (lat == 2) begin
                mv_done <= 1'b1;
                lat     <= 0;
                if (mv_cnt < 8) begin
                    mva_log[mv_cnt] <= mv_addr;
                    mvl_log[mv_cnt] <= 32'(mv_len);
                end
                mv_cnt <= mv_cnt + 1;
            end else lat <= lat + 1;
        end else begin
            mv_done <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            irq_cnt  <= 0;
            irq_wide <= 0;
            irq_d    <= 1'b0;
        end else begin
            irq_d <= irq;
            if (irq) irq_cnt <= irq_cnt + 1;
            if (irq && irq_d) irq_wide <= irq_wide + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; poll = 1'b0; base_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_desc(input int w, input logic [31:0] d0, d1, d2, d3);
        mem[w] = d0; mem[w+1] = d1; mem[w+2] = d2; mem[w+3] = d3;
    endtask

    task automatic pulse_start(input logic [31:0] b);
        @(negedge clk); base_addr = b; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_poll();
        @(negedge clk); poll = 1'b1;
        @(negedge clk); poll = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        for (int i = 0; i < 2000; i++) begin
            if (suspended || halted_err) break;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        do_reset();

        // R1: reset state, no fetch without start
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 mv_req", 32'(mv_req), 0);
        chk("R1 suspended", 32'(suspended), 0);
        chk("R1 halted_err", 32'(halted_err), 0);
        chk("R1 irq", 32'(irq), 0);
        repeat (10) @(negedge clk);
        chk("R1 no fetch before start", 32'(rd_cnt), 0);

        // ring: A@0x40 -> B@0x80 (size 0) -> C@0x20 (wrap) -> A again
        put_desc(16, 32'h8000_1234, 32'hA000_0040, 32'h0000_1000, 32'h0000_0080);
        put_desc(32, 32'h8000_00AA, 32'hA000_0000, 32'h0000_0003, 32'h0000_0020);
        put_desc(8,  32'h8000_0777, 32'h8200_0008, 32'h0000_2000, 32'h0000_0005);
        pulse_start(32'h40);
        settle();
        chk("R1 first fetch at base", rd_log[0], 32'h40);
        chk("R2 word1 addr", rd_log[1], 32'h44);
        chk("R2 word2 addr", rd_log[2], 32'h48);
        chk("R2 word3 addr", rd_log[3], 32'h4C);
        chk("R7 follows next pointer", rd_log[4], 32'h80);
        chk("R7 second next pointer", rd_log[8], 32'h20);
        chk("R7 wrap to base", rd_log[12], 32'h40);
        chk("R3 parks after wrap", 32'(suspended), 1);
        chk("R3 one read on host-owned", 32'(rd_cnt), 13);
        chk("R4 R5 transfer count", 32'(mv_cnt), 2);
        chk("R4 first addr", mva_log[0], 32'h1000);
        chk("R4 first len", mvl_log[0], 32'h40);
        chk("R4 second addr", mva_log[1], 32'h2000);
        chk("R4 second len", mvl_log[1], 32'h8);
        chk("R6 A written back", mem[16], 32'h0000_1234);
        chk("R5 R6 skipped B written back", mem[32], 32'h0000_00AA);
        chk("R6 C written back", mem[8], 32'h0000_0777);
        chk("R9 irq only with last segment", 32'(irq_cnt), 2);
        chk("R9 irq width", 32'(irq_wide), 0);
        chk("R8 no fault", 32'(halted_err), 0);

        // R3: parked walker stays quiet, poll re-reads same pointer
        repeat (20) @(negedge clk);
        chk("R3 quiet while parked", 32'(rd_cnt), 13);
        mem[16] = 32'h8000_0055;
        mem[17] = 32'h0000_0010;
        pulse_poll();
        settle();
        chk("R3 poll re-reads same word", rd_log[13], 32'h40);
        chk("R3 parks at next host-owned", rd_log[17], 32'h80);
        chk("R3 read count after poll", 32'(rd_cnt), 18);
        chk("R4 polled transfer len", mvl_log[2], 32'h10);
        chk("R9 no irq without request", 32'(irq_cnt), 2);
        chk("R6 status kept", mem[16], 32'h0000_0055);

        // R5/R8/R4 sweep: size 0..7 against buffer offset 0..3, wrap set
        for (int s = 0; s < 8; s++) begin
            for (int o = 0; o < 4; o++) begin
                do_reset();
                put_desc(0, 32'h8000_0000, 32'h0200_0000 | 32'(s), 32'h100 + 32'(o), 32'h0);
                pulse_start(32'h0);
                settle();
                if (s == 0) begin
                    chk("R5 zero size no move", 32'(mv_cnt), 0);
                    chk("R5 zero size no fault", 32'(halted_err), 0);
                    chk("R5 zero size written back", mem[0], 32'h0);
                end else if ((s % 4 != 0) || (o != 0)) begin
                    chk("R8 fault flag", 32'(halted_err), 1);
                    chk("R8 no move", 32'(mv_cnt), 0);
                    chk("R8 no write-back", mem[0], 32'h8000_0000);
                end else begin
                    chk("R4 sweep move", 32'(mv_cnt), 1);
                    chk("R4 sweep len", mvl_log[0], 32'(s));
                    chk("R6 sweep write-back", mem[0], 32'h0);
                    chk("R8 sweep no fault", 32'(halted_err), 0);
                end
            end
        end

        // R8: unaligned next pointer without wrap; fault ignores start
        do_reset();
        put_desc(0, 32'h8000_0000, 32'h0000_0004, 32'h100, 32'h22);
        pulse_start(32'h0);
        settle();
        chk("R8 unaligned next", 32'(halted_err), 1);
        chk("R8 unaligned next no move", 32'(mv_cnt), 0);
        begin
            int rc;
            rc = rd_cnt;
            pulse_start(32'h0);
            pulse_poll();
            repeat (10) @(negedge clk);
            chk("R8 sticky after start", 32'(halted_err), 1);
            chk("R8 no reads after start", 32'(rd_cnt), 32'(rc));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule